// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single command byte from a host controller to a PS/2 keyboard or mouse. Both bus lines are open-drain. The block never drives a line high: for each line it has one enable, and asserting that enable pulls the line to zero. When an enable is deasserted the line is released and an external pull-up brings it high.

A transfer starts when `start_i` is pulsed while the block is idle. The block first requests the bus by holding the clock line low for a programmable inhibit time, which is 100 µs at the default clock. It then puts the start bit (a low level) on the data line and releases the clock. From that point the device generates the clock. The block changes the data line only while the device holds the clock low. It sends the eight data bits least-significant first, then an odd parity bit. On the next clock fall it releases the data line. It then waits for the device to acknowledge, which the device does by pulling data low and then clock low.

Completion is signalled by a one-cycle `done_o` pulse. The surrounding controller uses this pulse to restart its receive timeout and to resume normal reception. It uses `busy_o` to keep its receiver paused during the transfer.

Top module: `ps2_cmd_sender`

## Requirements
- R1: After reset and whenever idle, `busy_o` and `done_o` are 0 and both drive-low enables are 0 (both lines released).
- R2: A `start_i` pulse while idle makes `busy_o` and `ps2_clk_low_o` 1 in the next cycle. The clock line is then held low for exactly INHIBIT_CYCLES+1 consecutive cycles.
- R3: `ps2_dat_low_o` rises in the last cycle of the clock hold, which is the (INHIBIT_CYCLES+1)-th cycle. It is still asserted when the clock is released, so the start bit reads 0.
- R4: The eight bits of the byte that `cmd_i` held when the start was accepted appear on the data line LSB first. A new bit is presented only after the synchronized clock is seen low, so a device sampling at its clock rising edges reads bits 0..7 in order.
- R5: The ninth bit the device samples is odd parity: it is 1 exactly when the byte contains an even number of ones.
- R6: A `start_i` pulse while `busy_o` is 1 is ignored. The command in flight is not altered, no second transfer begins, and `busy_o` stays 1 until the done pulse.
- R7: `done_o` is a single-cycle pulse issued with `busy_o` still 1. In the following cycle `busy_o` is 0.
- R8: The data line is released after the clock falls for the tenth time after release, so a device sampling the stop bit reads 1.
- R9: `done_o` is issued only after the data line is seen low (acknowledge) and, after that, the clock line is seen low. While the acknowledge is withheld, no done pulse occurs.
- R10: After a done pulse a new start is accepted at once, and each transfer produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to send `cmd_i` (one-cycle pulse) |
| cmd_i | input | 8 | Command byte, captured when the start is accepted |
| ps2_clk_i | input | 1 | Level of the PS/2 clock line (asynchronous) |
| ps2_dat_i | input | 1 | Level of the PS/2 data line (asynchronous) |
| ps2_clk_low_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| ps2_dat_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_o | output | 1 | Transfer in progress, from start acceptance through the done pulse |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong inhibit count shows on the clock enable within the first 100 µs as a hold of the wrong length. A sequencer stuck in a wait state shows as a device that stops clocking or a missing done pulse, both detected before the next transfer. A shift register or bit counter off by one corrupts the byte or the parity that the modelled device collects at its rising edges, and this is visible as soon as the frame ends. Premature completion, such as ignoring the acknowledge, is caught while the device deliberately withholds its acknowledge for a long gap.

// File: rtl/ps2tx_pkg.sv
// Package: shared types for the PS/2 host command transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package ps2tx_pkg;

    // Sequencer states of the transmitter
    typedef enum logic [3:0] {
        TX_IDLE,
        TX_INHIBIT,     // clock held low for the request time
        TX_START,       // start bit placed, clock still held
        TX_CLK_SETTLE,  // clock released, wait until seen high
        TX_BIT_LO,      // wait for device clock low, then present bit
        TX_BIT_HI,      // wait for device clock high, then advance
        TX_END_LO,      // wait for the clock fall after parity
        TX_DAT_SETTLE,  // data released, wait until seen high
        TX_ACK_DAT,     // wait for device to pull data low
        TX_ACK_CLK,     // wait for device to pull clock low
        TX_DONE         // one-cycle completion
    } tx_state_e;

endpackage

// File: rtl/ps2tx_sync.sv
// Module: ps2tx_sync
// Brings a set of asynchronous open-drain line levels into the clock
// domain through a chain of flops per line.
// Assumes: STAGES >= 2; idle lines read high, so flops reset to 1.
module ps2tx_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl_i,
    output logic [LINES-1:0] lvl_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        // Shift the raw level through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], lvl_i[g]};
        end

        assign lvl_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ps2tx_hold_timer.sv
// Module: ps2tx_hold_timer
// Down-counter that times the clock inhibit. A load sets it to
// HOLD_CYCLES-1. Each run cycle decrements it. zero_o marks expiry.
// Assumes: HOLD_CYCLES >= 1.
module ps2tx_hold_timer #(
    parameter int HOLD_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic zero_o
);

    localparam int TW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(HOLD_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    // Load on request, count down while running
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load_i)                cnt_q <= RELOAD;
        else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ps2tx_shifter.sv
// Module: ps2tx_shifter
// Holds the frame to send: the data bits and then the odd parity bit.
// bit_o is the bit to present now. last_o marks that bit_o is the
// parity bit, which is the final bit of the frame.
// Assumes: shift_i is only pulsed after a load.
module ps2tx_shifter #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [DATA_BITS-1:0] data_i,
    input  logic                 shift_i,
    output logic                 bit_o,
    output logic                 last_o
);

    localparam int FRAME = DATA_BITS + 1;
    localparam int CW    = $clog2(FRAME + 1);

    logic [FRAME-1:0] frame_q;
    logic [CW-1:0]    sent_q;

    // Capture byte plus odd parity, then shift LSB first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            sent_q  <= '0;
        end else if (load_i) begin
            frame_q <= {~^data_i, data_i};
            sent_q  <= '0;
        end else if (shift_i) begin
            frame_q <= {1'b0, frame_q[FRAME-1:1]};
            sent_q  <= sent_q + 1'b1;
        end
    end

    assign bit_o  = frame_q[0];
    assign last_o = (sent_q == CW'(FRAME - 1));

endmodule

// File: rtl/ps2_cmd_sender.sv
// Module: ps2_cmd_sender (top)
// Sends one byte from the host to a PS/2 device. The sequence is:
// a timed clock inhibit, the start bit, eight data bits LSB first,
// odd parity, release of the data line, and a wait for the device
// acknowledge. Both lines are open-drain. The outputs are registered
// drive-low enables.
// Assumes: ps2_*_i are the resolved line levels with pull-ups, and
// the device clock phases last longer than SYNC_STAGES+1 cycles.
module ps2_cmd_sender
    import ps2tx_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 20000,
    parameter int DATA_BITS      = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_BITS-1:0] cmd_i,
    input  logic                 ps2_clk_i,
    input  logic                 ps2_dat_i,
    output logic                 ps2_clk_low_o,
    output logic                 ps2_dat_low_o,
    output logic                 busy_o,
    output logic                 done_o
);

    localparam int LINE_CLK = 0;
    localparam int LINE_DAT = 1;

    tx_state_e state_q, state_n;
    logic      clk_drv_q, clk_drv_n;
    logic      dat_drv_q, dat_drv_n;
    logic      tmr_load, tmr_run, tmr_zero;
    logic      sh_load, sh_shift, sh_bit, sh_last;
    logic [1:0] lines_s;
    logic      clk_s, dat_s;

    ps2tx_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({ps2_dat_i, ps2_clk_i}),
        .lvl_o (lines_s)
    );

    assign clk_s = lines_s[LINE_CLK];
    assign dat_s = lines_s[LINE_DAT];

    ps2tx_hold_timer #(
        .HOLD_CYCLES (INHIBIT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .run_i  (tmr_run),
        .zero_o (tmr_zero)
    );

    ps2tx_shifter #(
        .DATA_BITS (DATA_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .data_i  (cmd_i),
        .shift_i (sh_shift),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    // Next-state and line-drive decisions of the transfer sequencer
    always_comb begin
        state_n   = state_q;
        clk_drv_n = clk_drv_q;
        dat_drv_n = dat_drv_q;
        tmr_load  = 1'b0;
        tmr_run   = 1'b0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (start_i) begin
                    state_n   = TX_INHIBIT;
                    clk_drv_n = 1'b1;
                    tmr_load  = 1'b1;
                    sh_load   = 1'b1;
                end
            end
            TX_INHIBIT: begin
                if (tmr_zero) begin
                    state_n   = TX_START;
                    dat_drv_n = 1'b1;
                end else begin
                    tmr_run = 1'b1;
                end
            end
            TX_START: begin
                clk_drv_n = 1'b0;
                state_n   = TX_CLK_SETTLE;
            end
            TX_CLK_SETTLE: begin
                if (clk_s) state_n = TX_BIT_LO;
            end
            TX_BIT_LO: begin
                if (!clk_s) begin
                    dat_drv_n = ~sh_bit;
                    state_n   = TX_BIT_HI;
                end
            end
            TX_BIT_HI: begin
                if (clk_s) begin
                    sh_shift = 1'b1;
                    state_n  = sh_last ? TX_END_LO : TX_BIT_LO;
                end
            end
            TX_END_LO: begin
                if (!clk_s) begin
                    dat_drv_n = 1'b0;
                    state_n   = TX_DAT_SETTLE;
                end
            end
            TX_DAT_SETTLE: begin
                if (dat_s) state_n = TX_ACK_DAT;
            end
            TX_ACK_DAT: begin
                if (!dat_s) state_n = TX_ACK_CLK;
            end
            TX_ACK_CLK: begin
                if (!clk_s) state_n = TX_DONE;
            end
            TX_DONE: begin
                state_n = TX_IDLE;
            end
            default: begin
                state_n   = TX_IDLE;
                clk_drv_n = 1'b0;
                dat_drv_n = 1'b0;
            end
        endcase
    end

    // State and registered drive enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= TX_IDLE;
            clk_drv_q <= 1'b0;
            dat_drv_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            clk_drv_q <= clk_drv_n;
            dat_drv_q <= dat_drv_n;
        end
    end

    assign ps2_clk_low_o = clk_drv_q;
    assign ps2_dat_low_o = dat_drv_q;
    assign busy_o        = (state_q != TX_IDLE);
    assign done_o        = (state_q == TX_DONE);

endmodule

// File: rtl/ps2tx_chk.sv
// Module: ps2tx_chk
// Port-level protocol checks for ps2_cmd_sender, bound into every
// instance. It observes the ports only.
// Assumes: same INHIBIT_CYCLES as the checked instance.
module ps2tx_chk #(
    parameter int INHIBIT_CYCLES = 20000
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ps2_clk_low_o,
    input logic ps2_dat_low_o,
    input logic busy_o,
    input logic done_o
);

    int unsigned hold_q;

    // Count consecutive cycles with the clock line driven low
    always_ff @(posedge clk) begin
        if (!rst_n)             hold_q <= 0;
        else if (ps2_clk_low_o) hold_q <= hold_q + 1;
        else                    hold_q <= 0;
    end

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ps2_clk_low_o && !ps2_dat_low_o));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && ps2_clk_low_o));

    // R2
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps2_clk_low_o) |-> (hold_q == INHIBIT_CYCLES + 1));

    // R3
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps2_clk_low_o) |-> ps2_dat_low_o);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R9
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ps2_clk_low_o && !ps2_dat_low_o));

endmodule

bind ps2_cmd_sender ps2tx_chk #(
    .INHIBIT_CYCLES (INHIBIT_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .ps2_clk_low_o (ps2_clk_low_o),
    .ps2_dat_low_o (ps2_dat_low_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
);

// File: tb/ps2_cmd_sender_test.sv
`timescale 1ns/1ps
module ps2_cmd_sender_test;

    localparam int INH = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic       dev_clk_low = 1'b0;
    logic       dev_dat_low = 1'b0;
    logic       clk_line, dat_line;
    logic       clk_low, dat_low, busy, done;

    assign clk_line = !(clk_low || dev_clk_low);
    assign dat_line = !(dat_low || dev_dat_low);

    ps2_cmd_sender #(.INHIBIT_CYCLES(INH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .cmd_i         (cmd),
        .ps2_clk_i     (clk_line),
        .ps2_dat_i     (dat_line),
        .ps2_clk_low_o (clk_low),
        .ps2_dat_low_o (dat_low),
        .busy_o        (busy),
        .done_o        (done)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_frame(input logic [7:0] b);
        return {~^b, b};
    endfunction

    // Port monitor: done pulses, clock hold length, start-bit timing
    int hold_run = 0, last_hold = 0, dat_rise_hold = 0, done_cnt = 0;
    bit prev_dat = 0, prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(!busy && !done, "R7 busy low after done", busy, 0);
            if (done) done_cnt++;
            if (clk_low) hold_run++;
            else begin
                if (hold_run != 0) last_hold = hold_run;
                hold_run = 0;
            end
            if (dat_low && !prev_dat && clk_low) dat_rise_hold = hold_run;
            prev_dat  = dat_low;
            prev_done = done;
        end
    end

    // Device model: clocks the frame out of the host, then acknowledges
    task automatic device(input int hp, input int ack_gap, output logic [8:0] got,
                          output bit st_ok, output bit stop_ok);
        int d0;
        while (clk_line) @(negedge clk);
        while (!clk_line) @(negedge clk);
        st_ok = !dat_line;
        repeat (hp) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            dev_clk_low = 1'b1;
            repeat (hp) @(negedge clk);
            got[i] = dat_line;
            dev_clk_low = 1'b0;
            repeat (hp) @(negedge clk);
        end
        dev_clk_low = 1'b1;
        repeat (hp) @(negedge clk);
        stop_ok = dat_line;
        dev_clk_low = 1'b0;
        d0 = done_cnt;
        repeat (hp + ack_gap) @(negedge clk);
        check(done_cnt == d0, "R9 no done before data ack", done_cnt - d0, 0);
        dev_dat_low = 1'b1;
        repeat (4) @(negedge clk);
        check(done_cnt == d0, "R9 no done before clock ack", done_cnt - d0, 0);
        dev_clk_low = 1'b1;
        repeat (hp) @(negedge clk);
        dev_clk_low = 1'b0;
        dev_dat_low = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] b, input int hp, input int ack_gap, input bit poke);
        logic [8:0] got;
        bit s_ok, p_ok;
        int d0;
        d0 = done_cnt;
        @(negedge clk);
        cmd = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cmd = ~b;
        check(busy && clk_low, "R2 start accepted", {busy, clk_low}, 3);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy && clk_low, "R6 start ignored while busy", {busy, clk_low}, 3);
        end
        device(hp, ack_gap, got, s_ok, p_ok);
        repeat (6) @(negedge clk);
        check(got[7:0] == b, "R4 data bits LSB first", got[7:0], b);
        check(got[8] == exp_frame(b)[8], "R5 odd parity", got[8], exp_frame(b)[8]);
        check(s_ok, "R3 start bit low at clock release", s_ok, 1);
        check(dat_rise_hold == INH + 1, "R3 start bit timing", dat_rise_hold, INH + 1);
        check(last_hold == INH + 1, "R2 inhibit length", last_hold, INH + 1);
        check(p_ok, "R8 data released for stop bit", p_ok, 1);
        check(done_cnt == d0 + 1, "R10 one done per transfer", done_cnt - d0, 1);
        check(!busy && !clk_low && !dat_low, "R1 idle after transfer", {busy, clk_low, dat_low}, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_2C6A));
        repeat (5) @(negedge clk);
        check(!busy && !done && !clk_low && !dat_low, "R1 reset state",
              {busy, done, clk_low, dat_low}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !clk_low && !dat_low, "R1 idle after reset", {busy, clk_low, dat_low}, 0);
        xfer(8'h00, 6, 0, 0);
        xfer(8'hFF, 8, 0, 0);
        xfer(8'h01, 10, 0, 0);
        xfer(8'h80, 7, 0, 0);
        xfer(8'hA5, 9, 0, 1);    // R6 start pulse mid-transfer
        xfer(8'hED, 6, 200, 0);  // R9 long withheld acknowledge
        for (int n = 0; n < 20; n++) begin
            xfer(8'($urandom), 6 + int'($urandom % 10), int'($urandom % 30), bit'($urandom % 2));
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule